// File: doc/BRIEF.md
# Interrupt Source Resend Controller

This block keeps the state of a bank of interrupt sources and turns commands into delivery requests for a presentation unit. Each source holds a priority, a target server number, a resend flag, a masked-pending flag and a registered copy of its level line. A source can be asked to deliver, to handle an end-of-interrupt, or to take new configuration. The presentation side can also ask for a resend scan. When a delivery fails, the source is marked for a later resend. When a delivery is blocked by a masked priority, the source is parked as masked-pending. It is never dropped.

All commands enter through one valid/ready port and run one at a time. A delivery request stays open until the presentation unit answers with success or failure. A successful answer may report a displaced interrupt. When the displaced source is not the inter-processor one, it is offered again at once through the same path. A failed answer raises a one-cycle pulse carrying the target server, so the target can set this bank's bit in its resend map.

Top module: `resend_ctl`

## Requirements
- R1: After reset `cmdReady` is 1, and both `dlvValid` and `mapSetValid` are 0. Every source starts with the masked priority (all ones) and all flags clear.
- R2: `cmdReady` is 0 from the cycle after a command is accepted until that command, with any re-delivery it triggers, is finished. A command presented during that time is held off and is taken afterwards.
- R3: A delivery command for an unmasked source raises `dlvValid` for exactly one cycle, in the cycle after acceptance. During that cycle `dlvIdx`, `dlvPrio` and `dlvServer` show the source's index, priority and server.
- R4: A delivery attempt to a source whose priority is all ones (masked) issues no request and sets the source's masked-pending flag.
- R5: Command op 3 (configure) writes priority and server. If the source is masked-pending and the new priority is not masked, the flag clears and one delivery attempt follows. Otherwise no request is made.
- R6: A failed response (`rspOk`=0) sets the source's resend flag. In the same cycle it raises `mapSetValid` with `mapSetServer` equal to the source's server.
- R7: Command op 2 (scan) walks the sources in ascending index order. It re-attempts every source whose resend flag is set and skips the rest. Each attempt clears that source's flag, so a scan that follows a fully successful one issues nothing.
- R8: Command op 1 (EOI) re-delivers the source when its registered level is 1. It does nothing when the level is 0.
- R9: A successful response with `rspRejValid`=1 and `rspRejIpi`=0 starts a delivery attempt for `rspRejIdx` straight away. With `rspRejIpi`=1, nothing further is issued.
- R10: A source that fails again during a scan stays flagged and is not retried within the same scan. The scan continues with the higher indices.
- R11: A flagged source that is masked when the scan reaches it becomes masked-pending instead. Its next unmasking configure replays it.

Command op 0 is deliver.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| cmdValid | input | 1 | Command present |
| cmdReady | output | 1 | Controller idle, command taken this cycle |
| cmdOp | input | 2 | 0 deliver, 1 EOI, 2 scan, 3 configure |
| cmdIdx | input | IDX_W | Source index |
| cmdPrio | input | PRIO_W | Priority for configure (all ones = masked) |
| cmdServer | input | SRV_W | Server number for configure |
| srcLevel | input | NUM_SRC | Level lines of the sources |
| dlvValid | output | 1 | Delivery request |
| dlvIdx | output | IDX_W | Source being delivered |
| dlvPrio | output | PRIO_W | Its priority |
| dlvServer | output | SRV_W | Its target server |
| rspValid | input | 1 | Presentation unit answer |
| rspOk | input | 1 | 1 delivered, 0 failed |
| rspRejValid | input | 1 | An earlier pending interrupt was displaced |
| rspRejIpi | input | 1 | The displaced one is the inter-processor source |
| rspRejIdx | input | IDX_W | Index of the displaced source |
| mapSetValid | output | 1 | Mark this bank in the target's resend map |
| mapSetServer | output | SRV_W | Target server for that mark |

## Verification
Two events can land on the same source in the same cycle. In one case, a scan moves past a source while a failed response is setting that source's resend flag again. In the other, a configure write unmasks a source while clearing its masked-pending flag and starting its replay. The first case is provoked by failing one of two flagged sources inside a scan. The test then checks that the scan still reaches the higher source, and that only the failed one appears on a second scan. The second case is judged by the replay request's fields and by the absence of any replay on a later reconfigure.

// File: rtl/rsc_pkg.sv
package rsc_pkg;
  typedef enum logic [1:0] {
    OP_DELIVER = 2'd0,
    OP_EOI     = 2'd1,
    OP_SCAN    = 2'd2,
    OP_CONFIG  = 2'd3
  } op_e;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_TRY,
    ST_WAIT,
    ST_SCAN
  } state_e;

  // Strobes from control to the source table; all act on the selected index.
  typedef struct packed {
    logic wrCfg;
    logic clrResend;
    logic setResend;
    logic setMaskPend;
    logic clrMaskPend;
  } strobe_t;
endpackage

// File: rtl/rsc_table.sv
module rsc_table
  import rsc_pkg::*;
#(
  parameter int NUM_SRC = 8,
  parameter int PRIO_W  = 8,
  parameter int SRV_W   = 4,
  parameter int IDX_W   = 3
) (
  input  logic               clk,
  input  logic               rstN,
  input  strobe_t            stb,
  input  logic [IDX_W-1:0]   selIdx,
  input  logic [PRIO_W-1:0]  cfgPrio,
  input  logic [SRV_W-1:0]   cfgServer,
  input  logic [NUM_SRC-1:0] srcLevel,
  output logic [PRIO_W-1:0]  selPrio,
  output logic [SRV_W-1:0]   selServer,
  output logic               selMasked,
  output logic               selLevel,
  output logic               selMaskPend,
  output logic [NUM_SRC-1:0] resendVec
);
  localparam logic [PRIO_W-1:0] MASKED = '1;

  logic [PRIO_W-1:0]  prioQ   [NUM_SRC];
  logic [SRV_W-1:0]   serverQ [NUM_SRC];
  logic [NUM_SRC-1:0] resendQ;
  logic [NUM_SRC-1:0] maskPendQ;
  logic [NUM_SRC-1:0] levelQ;

  for (genvar i = 0; i < NUM_SRC; i++) begin : g_src
    logic hit;
    assign hit = (selIdx == IDX_W'(i));

    always_ff @(posedge clk) begin
      if (!rstN) begin
        prioQ[i]     <= MASKED;
        serverQ[i]   <= '0;
        resendQ[i]   <= 1'b0;
        maskPendQ[i] <= 1'b0;
      end else if (hit) begin
        if (stb.wrCfg) begin
          prioQ[i]   <= cfgPrio;
          serverQ[i] <= cfgServer;
        end
        if (stb.setResend)        resendQ[i] <= 1'b1;
        else if (stb.clrResend)   resendQ[i] <= 1'b0;
        if (stb.setMaskPend)      maskPendQ[i] <= 1'b1;
        else if (stb.clrMaskPend) maskPendQ[i] <= 1'b0;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) levelQ <= '0;
    else       levelQ <= srcLevel;
  end

  assign selPrio     = prioQ[selIdx];
  assign selServer   = serverQ[selIdx];
  assign selMasked   = (prioQ[selIdx] == MASKED);
  assign selLevel    = levelQ[selIdx];
  assign selMaskPend = maskPendQ[selIdx];
  assign resendVec   = resendQ;
endmodule

// File: rtl/rsc_ctrl.sv
module rsc_ctrl
  import rsc_pkg::*;
#(
  parameter int NUM_SRC = 8,
  parameter int PRIO_W  = 8,
  parameter int IDX_W   = 3
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               cmdValid,
  input  logic [1:0]         cmdOp,
  input  logic [IDX_W-1:0]   cmdIdx,
  input  logic [PRIO_W-1:0]  cmdPrio,
  input  logic               rspValid,
  input  logic               rspOk,
  input  logic               rspRejValid,
  input  logic               rspRejIpi,
  input  logic [IDX_W-1:0]   rspRejIdx,
  input  logic               selMasked,
  input  logic               selLevel,
  input  logic               selMaskPend,
  input  logic [NUM_SRC-1:0] resendVec,
  output logic               cmdReady,
  output logic               dlvValid,
  output logic               mapSetValid,
  output logic [IDX_W-1:0]   selIdx,
  output logic [IDX_W-1:0]   curIdxOut,
  output strobe_t            stb
);
  localparam logic [IDX_W-1:0]  LAST   = IDX_W'(NUM_SRC - 1);
  localparam logic [PRIO_W-1:0] MASKED = '1;

  state_e           state, nState;
  logic [IDX_W-1:0] curIdx, nCur, scanIdx, nScan;
  logic             scanning, nScanning, doReturn;
  op_e              op;

  assign op        = op_e'(cmdOp);
  assign cmdReady  = (state == ST_IDLE);
  assign curIdxOut = curIdx;

  always_comb begin
    unique case (state)
      ST_IDLE: selIdx = cmdIdx;
      ST_SCAN: selIdx = scanIdx;
      default: selIdx = curIdx;
    endcase
  end

  always_comb begin
    stb         = '0;
    nState      = state;
    nCur        = curIdx;
    nScan       = scanIdx;
    nScanning   = scanning;
    dlvValid    = 1'b0;
    mapSetValid = 1'b0;
    doReturn    = 1'b0;
    unique case (state)
      ST_IDLE: if (cmdValid) begin
        nScanning = 1'b0;
        unique case (op)
          OP_DELIVER: begin nCur = cmdIdx; nState = ST_TRY; end
          OP_EOI: if (selLevel) begin nCur = cmdIdx; nState = ST_TRY; end
          OP_SCAN: begin nScan = '0; nScanning = 1'b1; nState = ST_SCAN; end
          OP_CONFIG: begin
            stb.wrCfg = 1'b1;
            if (selMaskPend && cmdPrio != MASKED) begin
              stb.clrMaskPend = 1'b1;
              nCur = cmdIdx;
              nState = ST_TRY;
            end
          end
        endcase
      end
      ST_TRY: begin
        stb.clrResend = 1'b1;
        if (selMasked) begin
          stb.setMaskPend = 1'b1;
          doReturn = 1'b1;
        end else begin
          dlvValid = 1'b1;
          nState = ST_WAIT;
        end
      end
      ST_WAIT: if (rspValid) begin
        if (!rspOk) begin
          stb.setResend = 1'b1;
          mapSetValid = 1'b1;
          doReturn = 1'b1;
        end else if (rspRejValid && !rspRejIpi) begin
          nCur = rspRejIdx;
          nState = ST_TRY;
        end else begin
          doReturn = 1'b1;
        end
      end
      ST_SCAN: begin
        if (resendVec[scanIdx]) begin
          nCur = scanIdx;
          nState = ST_TRY;
        end else begin
          doReturn = 1'b1;
        end
      end
    endcase
    if (doReturn) begin
      if (scanning && scanIdx != LAST) begin
        nScan = scanIdx + IDX_W'(1);
        nState = ST_SCAN;
      end else begin
        nState = ST_IDLE;
        nScanning = 1'b0;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state    <= ST_IDLE;
      curIdx   <= '0;
      scanIdx  <= '0;
      scanning <= 1'b0;
    end else begin
      state    <= nState;
      curIdx   <= nCur;
      scanIdx  <= nScan;
      scanning <= nScanning;
    end
  end
endmodule

// File: rtl/resend_ctl.sv
module resend_ctl
  import rsc_pkg::*;
#(
  parameter int NUM_SRC = 8,
  parameter int PRIO_W  = 8,
  parameter int SRV_W   = 4,
  localparam int IDX_W  = $clog2(NUM_SRC)
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               cmdValid,
  output logic               cmdReady,
  input  logic [1:0]         cmdOp,
  input  logic [IDX_W-1:0]   cmdIdx,
  input  logic [PRIO_W-1:0]  cmdPrio,
  input  logic [SRV_W-1:0]   cmdServer,
  input  logic [NUM_SRC-1:0] srcLevel,
  output logic               dlvValid,
  output logic [IDX_W-1:0]   dlvIdx,
  output logic [PRIO_W-1:0]  dlvPrio,
  output logic [SRV_W-1:0]   dlvServer,
  input  logic               rspValid,
  input  logic               rspOk,
  input  logic               rspRejValid,
  input  logic               rspRejIpi,
  input  logic [IDX_W-1:0]   rspRejIdx,
  output logic               mapSetValid,
  output logic [SRV_W-1:0]   mapSetServer
);
  strobe_t            stb;
  logic [IDX_W-1:0]   selIdx, curIdx;
  logic [PRIO_W-1:0]  selPrio;
  logic [SRV_W-1:0]   selServer;
  logic               selMasked, selLevel, selMaskPend;
  logic [NUM_SRC-1:0] resendVec;

  rsc_ctrl #(.NUM_SRC(NUM_SRC), .PRIO_W(PRIO_W), .IDX_W(IDX_W)) u_ctrl (
    .clk, .rstN, .cmdValid, .cmdOp, .cmdIdx, .cmdPrio,
    .rspValid, .rspOk, .rspRejValid, .rspRejIpi, .rspRejIdx,
    .selMasked, .selLevel, .selMaskPend, .resendVec,
    .cmdReady, .dlvValid, .mapSetValid, .selIdx, .curIdxOut(curIdx), .stb
  );

  rsc_table #(.NUM_SRC(NUM_SRC), .PRIO_W(PRIO_W), .SRV_W(SRV_W), .IDX_W(IDX_W)) u_table (
    .clk, .rstN, .stb, .selIdx, .cfgPrio(cmdPrio), .cfgServer(cmdServer), .srcLevel,
    .selPrio, .selServer, .selMasked, .selLevel, .selMaskPend, .resendVec
  );

  assign dlvIdx       = curIdx;
  assign dlvPrio      = selPrio;
  assign dlvServer    = selServer;
  assign mapSetServer = selServer;
endmodule

// File: rtl/rsc_checker.sv
module rsc_checker #(
  parameter int PRIO_W = 8
) (
  input logic              clk,
  input logic              rstN,
  input logic              cmdReady,
  input logic              dlvValid,
  input logic [PRIO_W-1:0] dlvPrio,
  input logic              mapSetValid
);
  AST_BUSY_DURING_REQ: assert property (@(posedge clk) disable iff (!rstN)
    dlvValid |-> !cmdReady); // R2
  AST_REQ_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rstN)
    dlvValid |=> !dlvValid); // R3
  AST_NO_MASKED_REQ: assert property (@(posedge clk) disable iff (!rstN)
    dlvValid |-> (dlvPrio != '1)); // R4
  AST_MAP_WHILE_BUSY: assert property (@(posedge clk) disable iff (!rstN)
    mapSetValid |-> !cmdReady); // R6
  AST_REQ_HOLDS_BUSY: assert property (@(posedge clk) disable iff (!rstN)
    dlvValid |=> !cmdReady); // R2
endmodule

bind resend_ctl rsc_checker #(.PRIO_W(PRIO_W)) u_chk (
  .clk(clk), .rstN(rstN), .cmdReady(cmdReady), .dlvValid(dlvValid),
  .dlvPrio(dlvPrio), .mapSetValid(mapSetValid)
);

// File: tb/resend_ctl_test.sv
`timescale 1ns/1ps
module resend_ctl_test;
  localparam int NS = 8, PW = 8, SW = 4, IW = 3;

  logic clk = 0, rstN = 0;
  logic cmdValid = 0, cmdReady;
  logic [1:0] cmdOp = 0;
  logic [IW-1:0] cmdIdx = 0;
  logic [PW-1:0] cmdPrio = 0;
  logic [SW-1:0] cmdServer = 0;
  logic [NS-1:0] srcLevel = 0;
  logic dlvValid;
  logic [IW-1:0] dlvIdx;
  logic [PW-1:0] dlvPrio;
  logic [SW-1:0] dlvServer;
  logic rspValid = 0, rspOk = 0, rspRejValid = 0, rspRejIpi = 0;
  logic [IW-1:0] rspRejIdx = 0;
  logic mapSetValid;
  logic [SW-1:0] mapSetServer;

  int checks = 0, failures = 0;
  bit done = 0;

  always #4 clk = ~clk;

  resend_ctl #(.NUM_SRC(NS), .PRIO_W(PW), .SRV_W(SW)) uut (.*);

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic sendCmd(input logic [1:0] op, input int idx, input int prio, input int srv);
    @(negedge clk);
    cmdOp = op; cmdIdx = IW'(idx); cmdPrio = PW'(prio); cmdServer = SW'(srv);
    cmdValid = 1;
    while (!cmdReady) @(negedge clk);
    @(negedge clk);
    cmdValid = 0;
  endtask

  // Wait for a request, check it, then answer it.
  task automatic serve(input string tag, input int idx, input int prio, input int srv,
                       input bit ok, input bit rejV, input bit rejIpi, input int rejIdx);
    bit seen = 0;
    for (int n = 0; n < 20; n++) begin
      if (dlvValid) begin seen = 1; break; end
      @(negedge clk);
    end
    chk(seen, {tag, " request seen"}, seen, 1);
    if (seen) begin
      chk(dlvIdx == IW'(idx), {tag, " idx"}, dlvIdx, idx);
      chk(dlvPrio == PW'(prio) && dlvServer == SW'(srv), {tag, " prio/server"},
          {dlvPrio, dlvServer}, {PW'(prio), SW'(srv)});
      @(negedge clk);
      rspValid = 1; rspOk = ok; rspRejValid = rejV; rspRejIpi = rejIpi; rspRejIdx = IW'(rejIdx);
      #1;
      if (!ok)
        chk(mapSetValid && mapSetServer == SW'(srv), {tag, " R6 map pulse"},
            {mapSetValid, mapSetServer}, {1'b1, SW'(srv)});
      @(negedge clk);
      rspValid = 0; rspRejValid = 0; rspRejIpi = 0;
    end
  endtask

  task automatic quiet(input string tag, input int n);
    bit any = 0;
    for (int k = 0; k < n; k++) begin
      @(negedge clk);
      if (dlvValid) any = 1;
    end
    chk(!any && cmdReady, {tag, " no request"}, any, 0);
  endtask

  task automatic t_reset();
    chk(cmdReady && !dlvValid && !mapSetValid, "R1 reset outputs",
        {cmdReady, dlvValid, mapSetValid}, 3'b100);
  endtask

  task automatic t_config();
    sendCmd(3, 1, 5, 3);
    sendCmd(3, 2, 7, 9);
    sendCmd(3, 5, 2, 1);
    sendCmd(3, 6, 4, 2);
    quiet("R5 plain config", 4);
  endtask

  task automatic t_deliver();
    sendCmd(0, 1, 0, 0);
    serve("R3 deliver src1", 1, 5, 3, 1, 0, 0, 0);
    quiet("R3 after ok", 3);
  endtask

  task automatic t_holdoff();
    sendCmd(0, 2, 0, 0);
    chk(!cmdReady, "R2 busy after accept", cmdReady, 0);
    cmdOp = 0; cmdIdx = 6; cmdValid = 1;
    serve("R2 first", 2, 7, 9, 1, 0, 0, 0);
    @(negedge clk);
    cmdValid = 0;
    serve("R2 held command", 6, 4, 2, 1, 0, 0, 0);
    quiet("R2 after", 3);
  endtask

  task automatic t_masked();
    sendCmd(0, 3, 0, 0);
    quiet("R4 masked src", 5);
    sendCmd(3, 3, 6, 4);
    serve("R5 unmask replay", 3, 6, 4, 1, 0, 0, 0);
    sendCmd(3, 3, 1, 4);
    quiet("R5 flag cleared", 5);
  endtask

  task automatic t_scan();
    sendCmd(0, 2, 0, 0);
    serve("R6 fail src2", 2, 7, 9, 0, 0, 0, 0);
    sendCmd(0, 5, 0, 0);
    serve("R6 fail src5", 5, 2, 1, 0, 0, 0, 0);
    sendCmd(2, 0, 0, 0);
    serve("R7 scan first", 2, 7, 9, 1, 0, 0, 0);
    serve("R7 scan second", 5, 2, 1, 1, 0, 0, 0);
    quiet("R7 scan end", 12);
    sendCmd(2, 0, 0, 0);
    quiet("R7 flags cleared", 14);
  endtask

  task automatic t_scanFail();
    sendCmd(0, 2, 0, 0);
    serve("R10 prep2", 2, 7, 9, 0, 0, 0, 0);
    sendCmd(0, 5, 0, 0);
    serve("R10 prep5", 5, 2, 1, 0, 0, 0, 0);
    sendCmd(2, 0, 0, 0);
    serve("R10 fail in scan", 2, 7, 9, 0, 0, 0, 0);
    serve("R10 scan continues", 5, 2, 1, 1, 0, 0, 0);
    quiet("R10 no retry same scan", 12);
    sendCmd(2, 0, 0, 0);
    serve("R10 next scan", 2, 7, 9, 1, 0, 0, 0);
    quiet("R10 done", 12);
  endtask

  task automatic t_eoi();
    srcLevel[6] = 1;
    repeat (2) @(negedge clk);
    sendCmd(1, 6, 0, 0);
    serve("R8 eoi asserted", 6, 4, 2, 1, 0, 0, 0);
    srcLevel[6] = 0;
    repeat (2) @(negedge clk);
    sendCmd(1, 6, 0, 0);
    quiet("R8 eoi deasserted", 5);
  endtask

  task automatic t_displace();
    sendCmd(0, 1, 0, 0);
    serve("R9 displacing", 1, 5, 3, 1, 1, 0, 5);
    serve("R9 displaced redelivered", 5, 2, 1, 1, 0, 0, 0);
    sendCmd(0, 1, 0, 0);
    serve("R9 ipi displaced", 1, 5, 3, 1, 1, 1, 0);
    quiet("R9 ipi not redelivered", 5);
  endtask

  task automatic t_scanMasked();
    sendCmd(0, 2, 0, 0);
    serve("R11 fail", 2, 7, 9, 0, 0, 0, 0);
    sendCmd(3, 2, 255, 9);
    quiet("R11 mask config", 3);
    sendCmd(2, 0, 0, 0);
    quiet("R11 scan masked", 14);
    sendCmd(3, 2, 7, 9);
    serve("R11 unmask replay", 2, 7, 9, 1, 0, 0, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1;
    @(negedge clk);
    t_reset();
    t_config();
    t_deliver();
    t_holdoff();
    t_masked();
    t_scan();
    t_scanFail();
    t_eoi();
    t_displace();
    t_scanMasked();
    if (!done) begin
      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      done = 1;
      checks++; failures++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule